// File: doc/BRIEF.md
# CEC Frame Receiver

This block listens to a single-wire consumer-electronics control bus and turns the line's low pulses back into frames. It times every low pulse and every falling-to-falling period in units of a programmable time base (10 µs per unit by default). Each pulse is then judged against separate tolerance windows for the start symbol, a logic 0 and a logic 1. Bits arrive most significant first. Every ten bits form one block: eight data bits, an end-of-message flag and an acknowledge slot. Each block is written as a 12-bit word into a 16-entry buffer that software reads through an index port.

The header's destination nibble is compared against five programmable address slots, each with its own valid flag. When the destination matches, the block pulls the line low during the acknowledge slot of every block. A frame to the broadcast address is kept but is never acknowledged by a low pulse. A frame to an address with no match is dropped without any trace.

A finished frame holds the receiver in a done state until software pulses a finish-clear. Completion, bit errors and buffer overflow each set a sticky status bit, and software clears a bit by writing 1 to it. Two controls limit what is captured:
- A reject control makes the receiver ignore incoming frames.
- A loopback control lets the receiver capture frames sent by this node's own transmitter, and frames sent to any destination.

Top module: `cec_frame_rx`

## Requirements
- R1: A start symbol is accepted only when its low time is 350–390 units and its period to the next falling edge is 430–470 units. Any other leading pulse starts no frame and sets no status.
- R2: After the start symbol, a low time of 40–80 units decodes as 1 and a low time of 130–170 units decodes as 0. Each bit period must be 205–275 units. Bits are taken most significant first: data bits 7..0, then the EOM bit, then the ACK bit.
- R3: Block k of a frame is stored at buffer index k. The stored word has data in [11:4], zeros in [3:2], the EOM bit in [1] and the sampled ACK level in [0], where 0 means acknowledged. On completion, rx_count equals the number of blocks.
- R4: The header destination (header bits [3:0]) is compared with every slot whose valid bit is set. Slot i occupies slot_addr[4i+3:4i]. Without a match, without broadcast and without loopback, the frame is dropped: nothing is stored, no status is set and no acknowledge is driven.
- R5: On a match, cec_drive_low pulls the line low for 150 units, starting at the falling edge of the ACK slot of every block.
- R6: A frame to destination 0xF is stored, and its ACK slot is never driven low.
- R7: A bit whose low time falls in neither bit window, a low time that reaches 182 units, or a bit period outside 205–275 units sets error status bit [1] and abandons the frame.
- R8: If 16 blocks arrive and none has EOM set, full status bit [2] is set and the frame is dropped. EOM set on block 16 completes the frame normally.
- R9: rx_status holds three sticky bits: [0] frame completed, [1] error, [2] full. Each bit stays set until the matching bit of stat_clr is pulsed.
- R10: After a completed frame, rx_done stays high and the line is ignored until finish_clr is pulsed.
- R11: While reject_next is high when a start symbol completes, the frame is ignored entirely.
- R12: A frame that starts while tx_active is high is ignored unless loopback_en is set. With loopback_en set, it is captured whatever its destination and is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cec_in | input | 1 | Bus line level (high = released) |
| tx_active | input | 1 | This node's transmitter is sending |
| loopback_en | input | 1 | Capture own and all-destination frames |
| reject_next | input | 1 | Ignore frames that start while high |
| finish_clr | input | 1 | Pulse that releases the done state |
| stat_clr | input | 3 | Write-1-to-clear pulses for rx_status |
| slot_addr | input | 20 | Five 4-bit logical addresses |
| slot_valid | input | 5 | Valid flag per address slot |
| rd_idx | input | 4 | Buffer read index |
| cec_drive_low | output | 1 | Pull bus low (acknowledge) |
| rx_done | output | 1 | Frame complete, waiting for finish_clr |
| rx_count | output | 5 | Blocks in the completed frame |
| rd_word | output | 12 | Buffer word at rd_idx |
| rx_status | output | 3 | Sticky status {full, error, done} |

## Verification
A wrong bit index or block counter shows up as shifted data in the read-back words, or as an acknowledge pulse in the wrong slot. Either is visible one frame later at rd_word and in the count of cec_drive_low pulses. A wrong match decision shows up at once: acknowledge pulses appear or vanish within the header block, and rx_done either rises or stays low. A timing window that is too narrow or too wide shows up within a single symbol as a spurious error bit or as a missing frame.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ST_LOW,
        S_ST_HIGH,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_DONE,
        S_SKIP
    } rx_state_e;

    localparam int WORD_W = 12;
endpackage

// File: rtl/cec_rx_tick.sv
module cec_rx_tick #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;
            always_comb begin
                cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign tick = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/cec_rx_edge.sv
module cec_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 3'b111;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[1];
    assign fall  = sh_q[2] & ~sh_q[1];
    assign rise  = ~sh_q[2] & sh_q[1];
endmodule

// File: rtl/cec_rx_addr_match.sv
module cec_rx_addr_match #(
    parameter int N_SLOTS = 5
) (
    input  logic [3:0]           dest,
    input  logic [N_SLOTS*4-1:0] slot_addr,
    input  logic [N_SLOTS-1:0]   slot_valid,
    output logic                 hit,
    output logic                 bcast
);
    logic [N_SLOTS-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < N_SLOTS; g++) begin : g_slot
            assign eq[g] = slot_valid[g] && (slot_addr[g*4 +: 4] == dest);
        end
    endgenerate

    assign hit   = |eq;
    assign bcast = (dest == 4'hF);
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
    import cec_rx_pkg::*;
#(
    parameter int TICK_CLKS   = 1000,
    parameter int N_SLOTS     = 5,
    parameter int DEPTH       = 16,
    parameter int START_L_MIN = 350,
    parameter int START_L_MAX = 390,
    parameter int START_P_MIN = 430,
    parameter int START_P_MAX = 470,
    parameter int ZERO_L_MIN  = 130,
    parameter int ZERO_L_MAX  = 170,
    parameter int ONE_L_MIN   = 40,
    parameter int ONE_L_MAX   = 80,
    parameter int BIT_P_MIN   = 205,
    parameter int BIT_P_MAX   = 275,
    parameter int LOW_ERR     = 182,
    parameter int ACK_LOW     = 150,
    localparam int IDX_W      = $clog2(DEPTH),
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cec_in,
    input  logic                 tx_active,
    input  logic                 loopback_en,
    input  logic                 reject_next,
    input  logic                 finish_clr,
    input  logic [2:0]           stat_clr,
    input  logic [N_SLOTS*4-1:0] slot_addr,
    input  logic [N_SLOTS-1:0]   slot_valid,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 cec_drive_low,
    output logic                 rx_done,
    output logic [CNT_W-1:0]     rx_count,
    output logic [WORD_W-1:0]    rd_word,
    output logic [2:0]           rx_status
);
    localparam int T_W = $clog2(START_P_MAX + 2);
    localparam logic [T_W-1:0] T_SAT  = '1;
    localparam logic [T_W-1:0] K_SLMN = T_W'(START_L_MIN);
    localparam logic [T_W-1:0] K_SLMX = T_W'(START_L_MAX);
    localparam logic [T_W-1:0] K_SPMN = T_W'(START_P_MIN);
    localparam logic [T_W-1:0] K_SPMX = T_W'(START_P_MAX);
    localparam logic [T_W-1:0] K_0MN  = T_W'(ZERO_L_MIN);
    localparam logic [T_W-1:0] K_0MX  = T_W'(ZERO_L_MAX);
    localparam logic [T_W-1:0] K_1MN  = T_W'(ONE_L_MIN);
    localparam logic [T_W-1:0] K_1MX  = T_W'(ONE_L_MAX);
    localparam logic [T_W-1:0] K_BPMN = T_W'(BIT_P_MIN);
    localparam logic [T_W-1:0] K_BPMX = T_W'(BIT_P_MAX);
    localparam logic [T_W-1:0] K_LERR = T_W'(LOW_ERR);
    localparam logic [T_W-1:0] K_ACK  = T_W'(ACK_LOW - 1);
    localparam logic [IDX_W-1:0] LAST_BLK = IDX_W'(DEPTH - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [T_W-1:0]   t;
        logic [3:0]       bi;
        logic [IDX_W-1:0] blk;
        logic [CNT_W-1:0] cnt;
        logic [8:0]       sh;
        logic [3:0]       dest;
        logic             ack_en;
        logic             own;
        logic             drive;
        logic [2:0]       stat;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              tick, line, fall, rise;
    logic              hit, bcast;
    logic              is_one, is_zero, hdr_last;
    logic [3:0]        dest_sel;
    logic              ok_set, err_set, full_set, wr_en;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] mem_q [DEPTH];

    function automatic logic in_win(logic [T_W-1:0] v, logic [T_W-1:0] lo, logic [T_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    cec_rx_tick #(.DIV(TICK_CLKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    cec_rx_edge u_edge (
        .clk(clk), .rst_n(rst_n), .raw(cec_in),
        .level(line), .fall(fall), .rise(rise)
    );

    assign is_one   = in_win(c_q.t, K_1MN, K_1MX);
    assign is_zero  = in_win(c_q.t, K_0MN, K_0MX);
    assign hdr_last = (c_q.st == S_BIT_LOW) && (c_q.bi == 4'd7) && (c_q.blk == '0);
    assign dest_sel = hdr_last ? {c_q.sh[2:0], is_one} : c_q.dest;

    cec_rx_addr_match #(.N_SLOTS(N_SLOTS)) u_match (
        .dest(dest_sel), .slot_addr(slot_addr), .slot_valid(slot_valid),
        .hit(hit), .bcast(bcast)
    );

    always_comb begin
        c_d      = c_q;
        ok_set   = 1'b0;
        err_set  = 1'b0;
        full_set = 1'b0;
        wr_en    = 1'b0;
        wr_word  = '0;
        if (tick && c_q.t != T_SAT) c_d.t = c_q.t + 1'b1;

        unique case (c_q.st)
            S_IDLE: begin
                if (fall) begin
                    c_d.st = S_ST_LOW;
                    c_d.t  = '0;
                end
            end
            S_ST_LOW: begin
                if (rise) begin
                    c_d.st = in_win(c_q.t, K_SLMN, K_SLMX) ? S_ST_HIGH : S_SKIP;
                    if (!in_win(c_q.t, K_SLMN, K_SLMX)) c_d.t = '0;
                end else if (c_q.t > K_SLMX) begin
                    c_d.st = S_SKIP;
                    c_d.t  = '0;
                end
            end
            S_ST_HIGH: begin
                if (fall) begin
                    c_d.t = '0;
                    if (in_win(c_q.t, K_SPMN, K_SPMX) && !reject_next &&
                        !(tx_active && !loopback_en)) begin
                        c_d.st     = S_BIT_LOW;
                        c_d.bi     = '0;
                        c_d.blk    = '0;
                        c_d.cnt    = '0;
                        c_d.own    = tx_active;
                        c_d.ack_en = 1'b0;
                    end else begin
                        c_d.st = S_SKIP;
                    end
                end else if (c_q.t > K_SPMX) begin
                    c_d.st = S_SKIP;
                    c_d.t  = '0;
                end
            end
            S_BIT_LOW: begin
                if (rise) begin
                    c_d.drive = 1'b0;
                    if (!is_one && !is_zero) begin
                        err_set = 1'b1;
                        c_d.st  = S_SKIP;
                        c_d.t   = '0;
                    end else if (c_q.bi == 4'd9) begin
                        wr_en   = 1'b1;
                        wr_word = {c_q.sh[8:1], 2'b00, c_q.sh[0], is_one};
                        c_d.bi  = '0;
                        if (c_q.sh[0]) begin
                            ok_set  = 1'b1;
                            c_d.st  = S_DONE;
                            c_d.cnt = CNT_W'(c_q.blk) + 1'b1;
                        end else if (c_q.blk == LAST_BLK) begin
                            full_set = 1'b1;
                            c_d.st   = S_SKIP;
                            c_d.t    = '0;
                        end else begin
                            c_d.blk = c_q.blk + 1'b1;
                            c_d.st  = S_BIT_HIGH;
                        end
                    end else begin
                        c_d.sh = {c_q.sh[7:0], is_one};
                        c_d.bi = c_q.bi + 1'b1;
                        c_d.st = S_BIT_HIGH;
                        if (hdr_last) begin
                            c_d.dest   = dest_sel;
                            c_d.ack_en = hit && !bcast && !c_q.own;
                            if (!(hit || bcast || loopback_en)) begin
                                c_d.st = S_SKIP;
                                c_d.t  = '0;
                            end
                        end
                    end
                end else if (c_q.t >= K_LERR) begin
                    err_set   = 1'b1;
                    c_d.st    = S_SKIP;
                    c_d.drive = 1'b0;
                end else if (c_q.drive && c_q.t >= K_ACK) begin
                    c_d.drive = 1'b0;
                end
            end
            S_BIT_HIGH: begin
                if (fall) begin
                    c_d.t = '0;
                    if (in_win(c_q.t, K_BPMN, K_BPMX)) begin
                        c_d.st    = S_BIT_LOW;
                        c_d.drive = (c_q.bi == 4'd9) && c_q.ack_en;
                    end else begin
                        err_set = 1'b1;
                        c_d.st  = S_SKIP;
                    end
                end else if (c_q.t > K_BPMX) begin
                    err_set = 1'b1;
                    c_d.st  = S_SKIP;
                    c_d.t   = '0;
                end
            end
            S_DONE: begin
                if (finish_clr) c_d.st = S_IDLE;
            end
            S_SKIP: begin
                if (fall || rise)                    c_d.t  = '0;
                else if (line && c_q.t >= K_BPMX)    c_d.st = S_IDLE;
            end
            default: c_d.st = S_IDLE;
        endcase

        c_d.stat = (c_q.stat & ~stat_clr) | {full_set, err_set, ok_set};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= S_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[c_q.blk] <= wr_word;
        end
    end

    assign cec_drive_low = c_q.drive;
    assign rx_done       = (c_q.st == S_DONE);
    assign rx_count      = c_q.cnt;
    assign rd_word       = mem_q[rd_idx];
    assign rx_status     = c_q.stat;

    a_r5_drive_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        cec_drive_low |-> hit);
    a_r6_no_bcast_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cec_drive_low |-> (c_q.dest != 4'hF));
    a_r12_no_own_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cec_drive_low |-> !c_q.own);
    a_r9_ok_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_status[0]) |-> rx_done);
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !finish_clr) |=> rx_done);
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (rx_count != '0 && rx_count <= CNT_W'(DEPTH)));
endmodule

// File: tb/sim_cec_frame_rx.sv
module sim_cec_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drv_h = 1'b1;
    logic        tx_active = 1'b0, loopback_en = 1'b0, reject_next = 1'b0, finish_clr = 1'b0;
    logic [2:0]  stat_clr = '0;
    logic [19:0] slot_addr;
    logic [4:0]  slot_valid;
    logic [3:0]  rd_idx = '0;
    logic        cec_drive_low, rx_done, cec_line;
    logic [4:0]  rx_count;
    logic [11:0] rd_word;
    logic [2:0]  rx_status;

    int total = 0, bad = 0, pulses = 0;
    logic drv_prev = 1'b0;
    logic [7:0] fb [16];

    always #5 clk = ~clk;
    assign cec_line = drv_h & ~cec_drive_low;

    cec_frame_rx #(.TICK_CLKS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .cec_in(cec_line), .tx_active(tx_active),
        .loopback_en(loopback_en), .reject_next(reject_next), .finish_clr(finish_clr),
        .stat_clr(stat_clr), .slot_addr(slot_addr), .slot_valid(slot_valid),
        .rd_idx(rd_idx), .cec_drive_low(cec_drive_low), .rx_done(rx_done),
        .rx_count(rx_count), .rd_word(rd_word), .rx_status(rx_status)
    );

    // reference: count acknowledge pulses seen on the output each clock
    always @(posedge clk) begin
        drv_prev <= cec_drive_low;
        if (cec_drive_low && !drv_prev) pulses <= pulses + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input int low, input int per);
        drv_h = 1'b0;
        repeat (low) @(negedge clk);
        drv_h = 1'b1;
        repeat (per - low) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input bit eom_last);
        send_bit(370, 450);
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) send_bit(fb[k][j] ? 60 : 150, 240);
            send_bit((eom_last && k == n - 1) ? 60 : 150, 240);
            send_bit(60, 240);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic check_words(input string tag, input int n, input bit acked);
        for (int i = 0; i < n; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(tag, int'(rd_word), int'({fb[i], 2'b00, (i == n - 1), ~acked}));
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        stat_clr = 3'b111; finish_clr = 1'b1;
        @(negedge clk);
        stat_clr = 3'b000; finish_clr = 1'b0;
        repeat (700) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p0;
        slot_addr  = {4'h9, 4'h0, 4'h7, 4'h4, 4'h2};
        slot_valid = 5'b10011;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        chk("R9 reset status", int'(rx_status), 0);
        chk("R10 reset done", int'(rx_done), 0);
        chk("R5 reset drive", int'(cec_drive_low), 0);
        chk("R3 reset count", int'(rx_count), 0);

        // matched frame to slot 1 (address 4)
        fb[0] = 8'h04; fb[1] = 8'h36; fb[2] = 8'hA5;
        p0 = pulses;
        send_frame(3, 1'b1);
        chk("R1 R10 done after frame", int'(rx_done), 1);
        chk("R3 count", int'(rx_count), 3);
        chk("R9 status ok", int'(rx_status), 1);
        chk("R5 ack pulses", pulses - p0, 3);
        check_words("R2 R3 word", 3, 1'b1);

        @(negedge clk); stat_clr = 3'b001;
        @(negedge clk); stat_clr = 3'b000;
        chk("R9 w1c clears", int'(rx_status), 0);
        chk("R10 done holds", int'(rx_done), 1);
        @(negedge clk); finish_clr = 1'b1;
        @(negedge clk); finish_clr = 1'b0;
        chk("R10 finish clear", int'(rx_done), 0);
        repeat (700) @(negedge clk);

        // slot 4 (address 9)
        fb[0] = 8'h39; fb[1] = 8'h80;
        p0 = pulses;
        send_frame(2, 1'b1);
        chk("R4 slot4 done", int'(rx_done), 1);
        chk("R5 slot4 pulses", pulses - p0, 2);
        check_words("R4 slot4 word", 2, 1'b1);
        clear_all();

        // broadcast
        fb[0] = 8'h2F; fb[1] = 8'h11;
        p0 = pulses;
        send_frame(2, 1'b1);
        chk("R6 bcast done", int'(rx_done), 1);
        chk("R6 bcast no pulse", pulses - p0, 0);
        check_words("R6 bcast word", 2, 1'b0);
        clear_all();

        // destination 7 sits in an invalid slot
        fb[0] = 8'h17; fb[1] = 8'h55;
        p0 = pulses;
        send_frame(2, 1'b1);
        chk("R4 unmatched done", int'(rx_done), 0);
        chk("R4 unmatched status", int'(rx_status), 0);
        chk("R4 unmatched pulses", pulses - p0, 0);
        clear_all();

        // own frame with loopback
        tx_active = 1'b1; loopback_en = 1'b1;
        fb[0] = 8'h47; fb[1] = 8'h12;
        p0 = pulses;
        send_frame(2, 1'b1);
        chk("R12 loopback done", int'(rx_done), 1);
        chk("R12 loopback pulses", pulses - p0, 0);
        check_words("R12 loopback word", 2, 1'b0);
        clear_all();

        // own frame without loopback
        loopback_en = 1'b0;
        fb[0] = 8'h04; fb[1] = 8'h12;
        p0 = pulses;
        send_frame(2, 1'b1);
        chk("R12 own ignored", int'(rx_done), 0);
        chk("R12 own pulses", pulses - p0, 0);
        tx_active = 1'b0;
        clear_all();

        // reject
        reject_next = 1'b1;
        p0 = pulses;
        send_frame(2, 1'b1);
        chk("R11 reject done", int'(rx_done), 0);
        chk("R11 reject status", int'(rx_status), 0);
        chk("R11 reject pulses", pulses - p0, 0);
        reject_next = 1'b0;
        clear_all();

        // bad start low time
        send_bit(300, 450);
        for (int j = 0; j < 8; j++) send_bit(150, 240);
        repeat (20) @(negedge clk);
        chk("R1 bad start done", int'(rx_done), 0);
        chk("R1 bad start status", int'(rx_status), 0);
        clear_all();

        // bad bit low time mid header
        send_bit(370, 450);
        send_bit(150, 240); send_bit(150, 240); send_bit(60, 240);
        send_bit(110, 240);
        repeat (20) @(negedge clk);
        chk("R7 bad bit error", int'(rx_status), 2);
        chk("R7 bad bit done", int'(rx_done), 0);
        clear_all();

        // overlong low inside a bit
        send_bit(370, 450);
        send_bit(200, 260);
        repeat (20) @(negedge clk);
        chk("R7 long low error", int'(rx_status), 2);
        clear_all();

        // 16 blocks without EOM
        for (int i = 0; i < 16; i++) fb[i] = (i == 0) ? 8'h04 : 8'(i * 13);
        p0 = pulses;
        send_frame(16, 1'b0);
        chk("R8 full status", int'(rx_status), 4);
        chk("R8 full done", int'(rx_done), 0);
        chk("R8 full pulses", pulses - p0, 16);
        clear_all();

        // 16 blocks with EOM on the last
        send_frame(16, 1'b1);
        chk("R8 16 done", int'(rx_done), 1);
        chk("R8 16 count", int'(rx_count), 16);
        check_words("R8 16 word", 16, 1'b1);
        clear_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule